// File: doc/BRIEF.md
# Cascadable Pipelined FIR Section

This block is a four-tap FIR section with run-time coefficients. A signed sample enters a shift chain of one-cycle registers. Each register position feeds its own two-stage pipelined multiplier, which multiplies it by that tap's coefficient. A single registered adder sums the four products at full precision into a wide signed result.

The sample that leaves the end of the shift chain is driven out on its own port. Several sections can then be chained into a longer filter, with the outputs of the sections added downstream. The coefficients are plain input ports. They may change on any cycle, and each tap's multiplier captures its coefficient directly.

The block applies no rounding and no saturation. Every register clears on an active-high reset, so both outputs read zero until samples have propagated.

Top module: `fir_section`

## Requirements
- R1: While reset is high, and after any rising edge at which reset was high, `filt_o` and `chain_o` are zero.
- R2: `chain_o` presents the sample captured at a rising edge after the fourth rising edge, counting the capturing one. It is therefore delayed by exactly four register stages.
- R3: Tap j (j = 0..3) takes its coefficient from `coef_i[9*j+8 : 9*j]`, a 9-bit two's-complement value. The product of a sample captured at edge k and the tap j coefficient is visible on `filt_o` after edge k+3+j.
- R4: `filt_o` is the exact signed sum of the four tap products, with no rounding and no truncation, for arbitrary signed samples and coefficients.
- R5: A coefficient value present at rising edge m is the one used for the product that reaches `filt_o` after edge m+2. Coefficient changes on consecutive cycles are therefore honoured cycle by cycle.
- R6: At the extreme input values the 20-bit output never wraps. Examples are sample -256 with all coefficients -256, giving +262144, and sample -256 with all coefficients +255, giving -261120.
- R7: Reset asserted in the middle of a stream clears all pipeline state. Filtering then restarts as if from power-up, with no residue from earlier samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 9 | Signed input sample |
| coef_i | input | 36 | Four signed 9-bit coefficients, tap j in bits 9*j+8 : 9*j |
| filt_o | output | 20 | Signed filter result |
| chain_o | output | 9 | Sample from the end of the shift chain, for the next section |

## Verification
A single nonzero sample against four distinct coefficients exposes tap order and per-tap latency. A design that swaps coefficient fields, or miscounts a pipeline stage, shifts or reorders the echoed coefficients.

Coefficients that change every cycle catch a multiplier that samples its coefficient one stage early or late. Such a design mixes neighbouring coefficient sets into each output.

Maximum-magnitude operands of both sign combinations catch products or partial sums held too narrow, or zero-extended instead of sign-extended. These show up as wrapped or positive-biased results.

A reset in the middle of a stream catches registers left out of the clear. Those leak old samples into the first outputs after restart.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // Width that holds the sum of `terms` signed values of `prod_w` bits without wrap.
    function automatic int acc_width(input int prod_w, input int terms);
        return prod_w + $clog2(terms);
    endfunction

    // Largest magnitude of a product of two signed operands of the given widths.
    function automatic longint prod_mag(input int aw, input int bw);
        return longint'(1) <<< (aw + bw - 2);
    endfunction

endpackage

// File: rtl/fir_tapline.sv
module fir_tapline #(
    parameter int TAPS = 4,
    parameter int W    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x_i,
    output logic [TAPS*W-1:0]   taps_o
);

    typedef struct packed {
        logic [TAPS-1:0][W-1:0] stage;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d          = line_q;
        line_d.stage[0] = x_i;
        for (int j = 1; j < TAPS; j++) begin
            line_d.stage[j] = line_q.stage[j-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign taps_o = line_q.stage;

    // R2
    head_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> line_q.stage[0] == $past(x_i));

    generate
        for (genvar j = 1; j < TAPS; j++) begin : g_shift_chk
            // R2
            shift_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> line_q.stage[j] == $past(line_q.stage[j-1]));
        end
    endgenerate

endmodule

// File: rtl/fir_mul2.sv
module fir_mul2 #(
    parameter int AW = 9,
    parameter int BW = 9,
    parameter int PW = AW + BW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [AW-1:0] a_i,
    input  logic signed [BW-1:0] b_i,
    output logic signed [PW-1:0] p_o
);

    typedef struct packed {
        logic signed [PW-1:0] s1;
        logic signed [PW-1:0] s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.s1 = PW'(a_i) * PW'(b_i);
        pipe_d.s2 = pipe_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign p_o = pipe_q.s2;

    // R5
    mul_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |->
            p_o == (PW'($past(a_i, 2)) * PW'($past(b_i, 2))));

endmodule

// File: rtl/fir_sum1.sv
module fir_sum1 #(
    parameter int N  = 4,
    parameter int IW = 18,
    parameter int OW = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N*IW-1:0]      in_i,
    output logic signed [OW-1:0] sum_o
);

    typedef struct packed {
        logic signed [OW-1:0] total;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d.total = '0;
        for (int i = 0; i < N; i++) begin
            acc_d.total = acc_d.total + OW'($signed(in_i[i*IW +: IW]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign sum_o = acc_q.total;

endmodule

// File: rtl/fir_section.sv
module fir_section #(
    parameter int TAPS     = 4,
    parameter int SAMPLE_W = 9,
    parameter int COEF_W   = 9
) (
    input  logic                                                clk,
    input  logic                                                rst,
    input  logic signed [SAMPLE_W-1:0]                          sample_i,
    input  logic [TAPS*COEF_W-1:0]                              coef_i,
    output logic signed [SAMPLE_W+COEF_W+$clog2(TAPS)-1:0]      filt_o,
    output logic signed [SAMPLE_W-1:0]                          chain_o
);

    localparam int PROD_W = SAMPLE_W + COEF_W;
    localparam int OUT_W  = fir_pkg::acc_width(PROD_W, TAPS);
    localparam longint BOUND = longint'(TAPS) * fir_pkg::prod_mag(SAMPLE_W, COEF_W);

    logic [TAPS*SAMPLE_W-1:0] tap_w;
    logic [TAPS*PROD_W-1:0]   prod_w;

    fir_tapline #(
        .TAPS (TAPS),
        .W    (SAMPLE_W)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .x_i    (sample_i),
        .taps_o (tap_w)
    );

    generate
        for (genvar j = 0; j < TAPS; j++) begin : g_tap
            fir_mul2 #(
                .AW (SAMPLE_W),
                .BW (COEF_W),
                .PW (PROD_W)
            ) u_mul (
                .clk (clk),
                .rst (rst),
                .a_i ($signed(tap_w[j*SAMPLE_W +: SAMPLE_W])),
                .b_i ($signed(coef_i[j*COEF_W +: COEF_W])),
                .p_o (prod_w[j*PROD_W +: PROD_W])
            );
        end
    endgenerate

    fir_sum1 #(
        .N  (TAPS),
        .IW (PROD_W),
        .OW (OUT_W)
    ) u_sum (
        .clk   (clk),
        .rst   (rst),
        .in_i  (prod_w),
        .sum_o (filt_o)
    );

    assign chain_o = $signed(tap_w[(TAPS-1)*SAMPLE_W +: SAMPLE_W]);

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (filt_o == '0 && chain_o == '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (longint'(filt_o) <= BOUND) && (longint'(filt_o) >= -BOUND));

endmodule

// File: tb/sim_fir_section.sv
module sim_fir_section;

    localparam int CLK_PERIOD = 20;
    localparam int HIST       = 4096;

    typedef struct {
        int    filt;
        int    chain;
        string tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [8:0] sample_i = '0;
    logic [35:0]       coef_i = '0;
    logic signed [19:0] filt_o;
    logic signed [8:0]  chain_o;

    int    checks = 0;
    int    errors = 0;
    int    n      = 0;
    bit    active = 1'b0;
    int    x_hist [HIST];
    int    h_hist [HIST][4];
    item_t sb_q [$];

    fir_section u0 (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .coef_i   (coef_i),
        .filt_o   (filt_o),
        .chain_o  (chain_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops one expected item per rising edge and compares.
    always begin
        @(posedge clk);
        #2;
        if (active && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (int'(filt_o) != it.filt) begin
                errors++;
                $display("FAIL %s filt_o got %0d exp %0d", it.tag, int'(filt_o), it.filt);
            end
            checks++;
            if (int'(chain_o) != it.chain) begin
                errors++;
                $display("FAIL R2 chain_o got %0d exp %0d (%s)", int'(chain_o), it.chain, it.tag);
            end
        end
    end

    // Driver: applies inputs for edge n and pushes the expected post-edge result.
    task automatic drive(input int x, input int h0, input int h1, input int h2,
                         input int h3, input string tag);
        item_t it;
        int    e;
        sample_i = 9'(x);
        coef_i   = {9'(h3), 9'(h2), 9'(h1), 9'(h0)};
        x_hist[n]    = x;
        h_hist[n][0] = h0;
        h_hist[n][1] = h1;
        h_hist[n][2] = h2;
        h_hist[n][3] = h3;
        e = 0;
        for (int j = 0; j < 4; j++) begin
            if (n - 3 - j >= 0) e += h_hist[n-2][j] * x_hist[n-3-j];
        end
        it.filt  = e;
        it.chain = (n - 3 >= 0) ? x_hist[n-3] : 0;
        it.tag   = tag;
        sb_q.push_back(it);
        n++;
        active = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset(input string tag);
        active   = 1'b0;
        rst      = 1'b1;
        sample_i = '0;
        coef_i   = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (filt_o != '0 || chain_o != '0) begin
            errors++;
            $display("FAIL %s reset outputs got filt %0d chain %0d exp 0 0",
                     tag, int'(filt_o), int'(chain_o));
        end
        sb_q.delete();
        n   = 0;
        rst = 1'b0;
    endtask

    function automatic int sx(input int i);
        return ((i * 73 + 29) % 512) - 256;
    endfunction

    function automatic int sh(input int i, input int j);
        return ((i * 31 + j * 57 + 5) % 512) - 256;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        do_reset("R1");

        // R3: single impulse reveals tap order and latency
        drive(1, 3, -5, 7, -11, "R3");
        for (int i = 0; i < 9; i++) drive(0, 3, -5, 7, -11, "R3");

        // R4: varied data, fixed coefficients
        for (int i = 0; i < 40; i++) drive(sx(i), 37, -90, 121, -4, "R4");

        // R5: coefficients change every cycle
        for (int i = 0; i < 40; i++)
            drive(sx(i + 7), sh(i, 0), sh(i, 1), sh(i, 2), sh(i, 3), "R5");

        // R6: extreme operands
        for (int i = 0; i < 8; i++) drive(-256, -256, -256, -256, -256, "R6");
        for (int i = 0; i < 8; i++) drive(-256, 255, 255, 255, 255, "R6");
        for (int i = 0; i < 8; i++) drive(255, -256, -256, -256, -256, "R6");
        for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 0, "R6");

        // R7: reset in the middle of a stream
        for (int i = 0; i < 6; i++) drive(sx(i + 3), 100, -100, 50, -50, "R7");
        do_reset("R7");
        for (int i = 0; i < 12; i++) drive(sx(i + 11), 9, 8, -7, 6, "R7");

        active = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule